// File: doc/BRIEF.md
# PWM Output Crossover and Disable Unit

This block sits between a three-phase PWM timing unit and the output pins. It receives six raw PWM signals, arranged as three high-side/low-side pairs, and produces the six pin-level signals. For each pair it can swap the high-side and low-side signals (crossover). After that swap it can force any individual pin to its off level (logic 0). This lets two inverter legs be driven with matched duty values while one leg is crossed and a third leg is parked off.

Software writes a 9-bit control word through a simple register port. A read returns the most recently written word. The written word is held in a shadow register. It is copied into the active register only on the rising edge of the cycle-start sync input, so a control change never lands in the middle of a PWM period. In double update mode, the rising edge of the midpoint sync input also copies the word. The path from the active register to the pins is purely combinational.

Top module: `pwm_oc_unit`

## Requirements
- R1: `reg_rd_data` returns the last value written through `reg_wr_en`/`reg_wr_data`; a write appears on the read port one clock after it is presented, and reads 0 after reset.
- R2: After reset the active control word is zero, so every pin follows its own raw input (`pin_hi[p] = raw_hi[p]`, `pin_lo[p] = raw_lo[p]`).
- R3: Active bit 8 crosses pair 0, bit 7 crosses pair 1 and bit 6 crosses pair 2. A crossed pair p drives `pin_hi[p]` from `raw_lo[p]` and `pin_lo[p]` from `raw_hi[p]`.
- R4: Active bits 5..0 force single pins to 0, with this mapping: bit 5 `pin_hi[0]`, bit 4 `pin_lo[0]`, bit 3 `pin_hi[1]`, bit 2 `pin_lo[1]`, bit 1 `pin_hi[2]`, bit 0 `pin_lo[2]`. A pin stays forced to 0 for as long as its bit stays set.
- R5: The disable bits act after the crossover. A disable bit names the pin it forces off, not the raw signal that feeds that pin.
- R6: A written value has no effect on the pins until a rising edge of `cyc_sync` is seen at a clock edge. Holding `cyc_sync` high latches only once.
- R7: When `dbl_update` is 1, a rising edge of `half_sync` also latches the written value. When `dbl_update` is 0, `half_sync` is ignored.
- R8: A write in the same clock as a latching edge is not applied; it waits for the next latching edge.
- R9: A change on the raw inputs reaches the pins in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 9 | Control word to write |
| reg_rd_data | output | 9 | Last written control word |
| cyc_sync | input | 1 | Cycle-start sync; rising edge latches the control word |
| half_sync | input | 1 | Midpoint sync; rising edge latches only in double update mode |
| dbl_update | input | 1 | 1 selects double update mode |
| raw_hi | input | 3 | Raw high-side signals from the timing unit, one per pair |
| raw_lo | input | 3 | Raw low-side signals from the timing unit, one per pair |
| pin_hi | output | 3 | High-side pin signals |
| pin_lo | output | 3 | Low-side pin signals |

## Verification
The assertions assume that the sync inputs are synchronous to `clk` and stable around its rising edge. They also assume that `dbl_update` changes only between sync edges. The bench drives every input on the falling clock edge, so both assumptions hold. Sync pulses are at least one full clock wide and low for at least one clock between pulses, so each intended edge is seen exactly once. Held-high sync and writes that coincide with a latching edge are applied on purpose, to exercise the edge detector and the shadow/active ordering.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;

  // Default number of high/low output pairs.
  localparam int DEF_PAIRS = 3;

  // Control word width: one crossover bit and two disable bits per pair.
  function automatic int ctrl_width(input int n_pairs);
    return 3 * n_pairs;
  endfunction

  // Crossover bit for pair p sits at the top of the word, pair 0 highest.
  function automatic int xo_bit(input int n_pairs, input int p);
    return ctrl_width(n_pairs) - 1 - p;
  endfunction

  // Disable bit for the high-side pin of pair p.
  function automatic int dis_hi_bit(input int n_pairs, input int p);
    return 2 * (n_pairs - 1 - p) + 1;
  endfunction

  // Disable bit for the low-side pin of pair p.
  function automatic int dis_lo_bit(input int n_pairs, input int p);
    return 2 * (n_pairs - 1 - p);
  endfunction

  // Crossover routing: returns {hi, lo} after the optional swap.
  function automatic logic [1:0] route_pair(input logic xo, input logic h, input logic l);
    return xo ? {l, h} : {h, l};
  endfunction

  // Disable gate: off level is logic 0.
  function automatic logic gate_off(input logic dis, input logic s);
    return s & ~dis;
  endfunction

endpackage

// File: rtl/pwm_oc_regport.sv
module pwm_oc_regport #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] shadow_o
);

  logic [W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (wr_en) begin
      shadow_q <= wr_data;
    end
  end

  assign shadow_o = shadow_q;

  AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> shadow_o == $past(wr_data)); // R1
  AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(shadow_o)); // R1

endmodule

// File: rtl/pwm_oc_syncpt.sv
module pwm_oc_syncpt (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic mid_i,
  input  logic dbl_i,
  output logic sync_rise_o,
  output logic mid_rise_o,
  output logic latch_o
);

  logic sync_q;
  logic mid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      mid_q  <= 1'b0;
    end else begin
      sync_q <= sync_i;
      mid_q  <= mid_i;
    end
  end

  // Edge events brought out as named wires.
  assign sync_rise_o = sync_i & ~sync_q;
  assign mid_rise_o  = mid_i & ~mid_q;
  assign latch_o     = sync_rise_o | (dbl_i & mid_rise_o);

  AST_SINGLE_NO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_i && !sync_rise_o) |-> !latch_o); // R7
  AST_HELD_SYNC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !mid_i) |=> (sync_i && !mid_i) |-> !latch_o); // R6

endmodule

// File: rtl/pwm_oc_active.sv
module pwm_oc_active #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         latch_i,
  input  logic [W-1:0] shadow_i,
  output logic [W-1:0] active_o
);

  logic [W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (latch_i) begin
      active_q <= shadow_i;
    end
  end

  assign active_o = active_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(active_o)); // R6
  AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> active_o == $past(shadow_i)); // R8

endmodule

// File: rtl/pwm_oc_lane.sv
module pwm_oc_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic xo_i,
  input  logic dis_hi_i,
  input  logic dis_lo_i,
  input  logic raw_hi_i,
  input  logic raw_lo_i,
  output logic pin_hi_o,
  output logic pin_lo_o
);

  import pwm_oc_pkg::*;

  // Crossover stage result, named for the assertions.
  logic routed_hi;
  logic routed_lo;

  always_comb begin
    {routed_hi, routed_lo} = route_pair(xo_i, raw_hi_i, raw_lo_i);
  end

  // Disable stage after crossover.
  assign pin_hi_o = gate_off(dis_hi_i, routed_hi);
  assign pin_lo_o = gate_off(dis_lo_i, routed_lo);

  AST_OFF_HI: assert property (@(posedge clk) disable iff (!rst_n)
    dis_hi_i |-> !pin_hi_o); // R4
  AST_OFF_LO: assert property (@(posedge clk) disable iff (!rst_n)
    dis_lo_i |-> !pin_lo_o); // R4
  AST_XO_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (xo_i && !dis_lo_i) |-> pin_lo_o == raw_hi_i); // R3
  AST_XO_TO_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (xo_i && !dis_hi_i) |-> pin_hi_o == raw_lo_i); // R5

endmodule

// File: rtl/pwm_oc_unit.sv
module pwm_oc_unit #(
  parameter int N_PAIRS = pwm_oc_pkg::DEF_PAIRS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr_en,
  input  logic [3*N_PAIRS-1:0]          reg_wr_data,
  output logic [3*N_PAIRS-1:0]          reg_rd_data,
  input  logic                          cyc_sync,
  input  logic                          half_sync,
  input  logic                          dbl_update,
  input  logic [N_PAIRS-1:0]            raw_hi,
  input  logic [N_PAIRS-1:0]            raw_lo,
  output logic [N_PAIRS-1:0]            pin_hi,
  output logic [N_PAIRS-1:0]            pin_lo
);

  import pwm_oc_pkg::*;

  localparam int CW = 3 * N_PAIRS;

  logic [CW-1:0] shadow_w;
  logic [CW-1:0] active_w;
  logic          sync_rise_w;
  logic          mid_rise_w;
  logic          latch_w;

  pwm_oc_regport #(.W(CW)) u_regport (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_data  (reg_wr_data),
    .shadow_o (shadow_w)
  );

  assign reg_rd_data = shadow_w;

  pwm_oc_syncpt u_syncpt (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (cyc_sync),
    .mid_i       (half_sync),
    .dbl_i       (dbl_update),
    .sync_rise_o (sync_rise_w),
    .mid_rise_o  (mid_rise_w),
    .latch_o     (latch_w)
  );

  pwm_oc_active #(.W(CW)) u_active (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_i  (latch_w),
    .shadow_i (shadow_w),
    .active_o (active_w)
  );

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_lane
    pwm_oc_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .xo_i     (active_w[xo_bit(N_PAIRS, p)]),
      .dis_hi_i (active_w[dis_hi_bit(N_PAIRS, p)]),
      .dis_lo_i (active_w[dis_lo_bit(N_PAIRS, p)]),
      .raw_hi_i (raw_hi[p]),
      .raw_lo_i (raw_lo[p]),
      .pin_hi_o (pin_hi[p]),
      .pin_lo_o (pin_lo[p])
    );
  end

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w == '0) |-> (pin_hi == raw_hi && pin_lo == raw_lo)); // R2
  AST_MID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_update && mid_rise_w && !sync_rise_w) |=> $stable(active_w)); // R7
  AST_MID_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_update && mid_rise_w) |=> active_w == $past(shadow_w)); // R7

endmodule

// File: tb/pwm_oc_unit_test.sv
`timescale 1ns/1ps
module pwm_oc_unit_test;

  localparam int NP = 3;
  localparam int CW = 3 * NP;
  localparam int NV = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [CW-1:0] reg_wr_data = '0;
  logic [CW-1:0] reg_rd_data;
  logic          cyc_sync = 1'b0;
  logic          half_sync = 1'b0;
  logic          dbl_update = 1'b0;
  logic [NP-1:0] raw_hi = '0;
  logic [NP-1:0] raw_lo = '0;
  logic [NP-1:0] pin_hi;
  logic [NP-1:0] pin_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_oc_unit #(.N_PAIRS(NP)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .cyc_sync(cyc_sync), .half_sync(half_sync), .dbl_update(dbl_update),
    .raw_hi(raw_hi), .raw_lo(raw_lo), .pin_hi(pin_hi), .pin_lo(pin_lo)
  );

  // {control, raw_hi, raw_lo, expected pin_hi, expected pin_lo}
  localparam logic [20:0] VEC [0:NV-1] = '{
    {9'h000, 3'b101, 3'b010, 3'b101, 3'b010},
    {9'h100, 3'b101, 3'b010, 3'b100, 3'b011},
    {9'h080, 3'b111, 3'b000, 3'b101, 3'b010},
    {9'h040, 3'b000, 3'b111, 3'b100, 3'b011},
    {9'h03F, 3'b111, 3'b111, 3'b000, 3'b000},
    {9'h020, 3'b111, 3'b111, 3'b110, 3'b111},
    {9'h003, 3'b111, 3'b111, 3'b011, 3'b011},
    {9'h120, 3'b001, 3'b000, 3'b000, 3'b001},
    {9'h110, 3'b001, 3'b001, 3'b001, 3'b000},
    {9'h088, 3'b010, 3'b010, 3'b000, 3'b010},
    {9'h044, 3'b111, 3'b000, 3'b011, 3'b100}
  };

  task automatic chk_pins(input string req, input logic [NP-1:0] eh, input logic [NP-1:0] el);
    n_chk++;
    if (pin_hi !== eh || pin_lo !== el) begin
      n_bad++;
      $display("FAIL %s: pin_hi=%b pin_lo=%b expected pin_hi=%b pin_lo=%b",
               req, pin_hi, pin_lo, eh, el);
    end
  endtask

  task automatic chk_rd(input string req, input logic [CW-1:0] exp);
    n_chk++;
    if (reg_rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: reg_rd_data=%h expected %h", req, reg_rd_data, exp);
    end
  endtask

  task automatic wr(input logic [CW-1:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); cyc_sync = 1'b1;
    @(negedge clk); cyc_sync = 1'b0;
  endtask

  task automatic pulse_mid();
    @(negedge clk); half_sync = 1'b1;
    @(negedge clk); half_sync = 1'b0;
  endtask

  task automatic set_raw(input logic [NP-1:0] h, input logic [NP-1:0] l);
    raw_hi = h; raw_lo = l; #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    set_raw(3'b101, 3'b011);
    chk_pins("R2 reset pass-through", 3'b101, 3'b011);
    chk_rd("R1 reset read", 9'h000);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk_pins("R2 after reset", 3'b101, 3'b011);

    // Table walk: R3 R4 R5 mapping, R1 read-back
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][20:12]);
      chk_rd("R1 table read-back", VEC[i][20:12]);
      pulse_sync();
      set_raw(VEC[i][11:9], VEC[i][8:6]);
      chk_pins($sformatf("R3 R4 R5 table vector %0d", i), VEC[i][5:3], VEC[i][2:0]);
    end

    // R7: midpoint ignored in single mode, applied in double mode
    wr(9'h000); pulse_sync();
    set_raw(3'b111, 3'b111);
    wr(9'h03F);
    chk_pins("R6 write without sync", 3'b111, 3'b111);
    pulse_mid(); #1;
    chk_pins("R7 midpoint ignored single mode", 3'b111, 3'b111);
    @(negedge clk); dbl_update = 1'b1;
    pulse_mid(); #1;
    chk_pins("R7 midpoint latches double mode", 3'b000, 3'b000);
    @(negedge clk); dbl_update = 1'b0;

    // R6: held sync latches once
    wr(9'h000);
    @(negedge clk); cyc_sync = 1'b1;
    @(negedge clk); #1;
    chk_pins("R6 sync rising edge latches", 3'b111, 3'b111);
    wr(9'h03F);
    repeat (3) @(negedge clk);
    #1;
    chk_pins("R6 held sync no second latch", 3'b111, 3'b111);
    cyc_sync = 1'b0;
    @(negedge clk); #1;
    chk_pins("R6 sync fall no latch", 3'b111, 3'b111);
    pulse_sync(); #1;
    chk_pins("R6 next rising edge latches", 3'b000, 3'b000);
    chk_pins("R4 disable holds while set", 3'b000, 3'b000);

    // R8: write coinciding with latch edge waits
    wr(9'h000); pulse_sync();
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = 9'h03F; cyc_sync = 1'b1;
    @(negedge clk); reg_wr_en = 1'b0; cyc_sync = 1'b0; #1;
    chk_pins("R8 coincident write not applied", 3'b111, 3'b111);
    chk_rd("R8 coincident write stored", 9'h03F);
    pulse_sync(); #1;
    chk_pins("R8 applied on next edge", 3'b000, 3'b000);

    // R9: raw changes pass combinationally
    wr(9'h100); pulse_sync();
    set_raw(3'b001, 3'b000);
    chk_pins("R9 crossed pair 0 first", 3'b000, 3'b001);
    #3; set_raw(3'b000, 3'b001);
    chk_pins("R9 same-cycle raw change", 3'b001, 3'b000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule